// File: doc/BRIEF.md
# Serial DAC Word Loader

This block receives 16-bit command words for a dual 8-bit digital-to-analog converter over a write-only three-wire serial link. The link carries an active-low frame select, a serial clock and a data line. All three inputs are asynchronous to the block clock. The block samples them with `clk_i`, which must run at least six times faster than the serial clock. Each frame holds a 4-bit select field, an 8-bit converter code and four pad bits, and is shifted in most significant bit first.

When a frame closes, the select field decides where the code goes: the channel A latch, the channel B latch, a shared staging buffer, or a small control register. Writing channel A also copies the staging buffer into channel B in the same cycle, so both channels can change together. A frame closes on its sixteenth bit. If the select line goes high before that, the frame closes early and the missing low bits read as zero.

Top module: `sdl_word_loader`

## Requirements
- R1: While `rst_ni` is low, `dac_a_o`, `dac_b_o`, `buf_o`, `speed_o` and `pwrdn_o` are all zero.
- R2: A falling edge of `cs_ni` starts a frame. Bits are taken from `din_i` on falling edges of `sclk_i` while `cs_ni` is low, MSB first. Word bits 15..12 are the select, bits 11..4 are the code, and bits 3..0 are ignored.
- R3: Select 4'b0000 loads the code into `dac_a_o` and copies the previous `buf_o` into `dac_b_o`.
- R4: Select 4'b0001 loads the code into `buf_o` only.
- R5: Select 4'b1000 loads the code into `dac_b_o` only.
- R6: Select 4'b1001 sets `speed_o` from word bit 4 and `pwrdn_o` from word bit 5, and leaves the three code outputs alone.
- R7: Any other select value changes no output. While no frame commits, the outputs hold their values.
- R8: A frame commits on its 16th bit. Further serial clock edges before `cs_ni` rises are ignored, and the rise that follows commits nothing.
- R9: If `cs_ni` rises after k bits, with 1 <= k <= 15, the frame commits as if the remaining low bits were zero. If it rises after zero bits, nothing commits.
- R10: Serial clock edges while `cs_ni` is high have no effect.
- R11: A frame may arrive as two 8-bit bursts separated by an idle gap, provided `cs_ni` stays low between them.
- R12: An output updates no later than the fourth `clk_i` rising edge after the input edge that commits the frame. This assumes each serial input level is held for at least three `clk_i` periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the serial link |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock, data taken on falling edges |
| din_i | input | 1 | Serial data, MSB first |
| dac_a_o | output | 8 | Channel A code |
| dac_b_o | output | 8 | Channel B code |
| buf_o | output | 8 | Staging buffer contents |
| speed_o | output | 1 | Speed-mode setting |
| pwrdn_o | output | 1 | Power-down setting |

## Verification
Each serial input passes through two synchronizer flops and one edge-detect flop. The framer then registers a commit pulse, and the latches update on the following edge, so results appear four block-clock edges after the committing serial edge. The driver holds every serial level for four block clocks. It queues each expected output set with a due cycle that falls well after this latency and before the next frame starts. The monitor compares on falling clock edges once the due cycle has passed. Because of this, a result that arrives too late, or a stray change between frames, shows up as a miscompare.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_A_XFER = 4'b0000,  // code -> A, buffer -> B
    SEL_BUF    = 4'b0001,
    SEL_B      = 4'b1000,
    SEL_CTRL   = 4'b1001
  } sel_e;

  localparam int CTRL_SPEED_BIT = 0;
  localparam int CTRL_PWRDN_BIT = 1;
endpackage

// File: rtl/sdl_sync_edge.sv
module sdl_sync_edge #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= {STAGES{RST_VAL[g]}};
        prev_q <= RST_VAL[g];
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], async_i[g]};
        prev_q <= sh_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = sh_q[STAGES-1];
    assign rise_o[g] = sh_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~sh_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/sdl_framer.sv
module sdl_framer #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_lvl_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_fall_i,
  input  logic              din_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q, shreg_nxt, padded;
  logic              commit_q;
  logic [WORD_W-1:0] word_q;

  assign shreg_nxt = {shreg_q[WORD_W-2:0], din_i};
  // short frame: left-align received bits, zero the rest
  assign padded    = shreg_q << (CNT_W'(WORD_W) - cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      commit_q <= 1'b0;
      word_q   <= '0;
    end else begin
      commit_q <= 1'b0;
      if (cs_fall_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        shreg_q  <= '0;
      end else if (cs_rise_i) begin
        if (active_q && cnt_q != '0) begin
          commit_q <= 1'b1;
          word_q   <= padded;
        end
        active_q <= 1'b0;
      end else if (active_q && !cs_lvl_i && sclk_fall_i) begin
        shreg_q <= shreg_nxt;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          commit_q <= 1'b1;
          word_q   <= shreg_nxt;
          active_q <= 1'b0;
        end
      end
    end
  end

  assign commit_o = commit_q;
  assign word_o   = word_q;
endmodule

// File: rtl/sdl_latches.sv
module sdl_latches
  import sdl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAD_W  = 4,
  localparam int WORD_W = SEL_W + DATA_W + PAD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              speed_o,
  output logic              pwrdn_o
);
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] code;
  logic              unused_pad;

  assign sel        = word_i[WORD_W-1 -: SEL_W];
  assign code       = word_i[PAD_W +: DATA_W];
  assign unused_pad = ^word_i[PAD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_a_o <= '0;
      dac_b_o <= '0;
      buf_o   <= '0;
      speed_o <= 1'b0;
      pwrdn_o <= 1'b0;
    end else if (commit_i) begin
      case (sel)
        SEL_A_XFER: begin
          dac_a_o <= code;
          dac_b_o <= buf_o;
        end
        SEL_BUF:  buf_o   <= code;
        SEL_B:    dac_b_o <= code;
        SEL_CTRL: begin
          speed_o <= code[CTRL_SPEED_BIT];
          pwrdn_o <= code[CTRL_PWRDN_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdl_word_loader.sv
module sdl_word_loader
  import sdl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PAD_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = SEL_W + DATA_W + PAD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              speed_o,
  output logic              pwrdn_o
);
  // bit 2 = cs (idles high), 1 = sclk, 0 = din
  logic [2:0] lvl, rise, fall;
  logic              frame_commit;
  logic [WORD_W-1:0] frame_word;
  logic              unused_edges;

  assign unused_edges = rise[1] ^ rise[0] ^ fall[0] ^ lvl[1];

  sdl_sync_edge #(
    .N      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({cs_ni, sclk_i, din_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  sdl_framer #(
    .WORD_W(WORD_W)
  ) i_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_lvl_i   (lvl[2]),
    .cs_fall_i  (fall[2]),
    .cs_rise_i  (rise[2]),
    .sclk_fall_i(fall[1]),
    .din_i      (lvl[0]),
    .commit_o   (frame_commit),
    .word_o     (frame_word)
  );

  sdl_latches #(
    .DATA_W(DATA_W),
    .PAD_W (PAD_W)
  ) i_latches (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(frame_commit),
    .word_i  (frame_word),
    .dac_a_o (dac_a_o),
    .dac_b_o (dac_b_o),
    .buf_o   (buf_o),
    .speed_o (speed_o),
    .pwrdn_o (pwrdn_o)
  );
endmodule

// File: rtl/sdl_word_loader_chk.sv
module sdl_word_loader_chk
  import sdl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAD_W  = 4,
  localparam int WORD_W = SEL_W + DATA_W + PAD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_commit,
  input logic [WORD_W-1:0] frame_word,
  input logic [DATA_W-1:0] dac_a_o,
  input logic [DATA_W-1:0] dac_b_o,
  input logic [DATA_W-1:0] buf_o,
  input logic              speed_o,
  input logic              pwrdn_o
);
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] code;
  logic              hold_all;
  assign sel  = frame_word[WORD_W-1 -: SEL_W];
  assign code = frame_word[PAD_W +: DATA_W];
  assign hold_all = !frame_commit || !(sel inside {SEL_A_XFER, SEL_BUF, SEL_B, SEL_CTRL});

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (dac_a_o == '0 && dac_b_o == '0 && buf_o == '0 && !speed_o && !pwrdn_o);
    end
  end

  // R3
  wr_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_commit && sel == SEL_A_XFER |=> dac_a_o == $past(code) && dac_b_o == $past(buf_o));

  // R4
  wr_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_commit && sel == SEL_BUF |=> buf_o == $past(code) && $stable(dac_a_o) && $stable(dac_b_o));

  // R5
  wr_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_commit && sel == SEL_B |=> dac_b_o == $past(code) && $stable(dac_a_o) && $stable(buf_o));

  // R6
  wr_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_commit && sel == SEL_CTRL |=> speed_o == $past(frame_word[PAD_W + CTRL_SPEED_BIT])
      && pwrdn_o == $past(frame_word[PAD_W + CTRL_PWRDN_BIT]) && $stable(dac_a_o) && $stable(buf_o));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_all |=> $stable(dac_a_o) && $stable(dac_b_o) && $stable(buf_o)
      && $stable(speed_o) && $stable(pwrdn_o));

  // R8
  single_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_commit |=> !frame_commit);
endmodule

bind sdl_word_loader sdl_word_loader_chk #(
  .DATA_W(DATA_W),
  .PAD_W (PAD_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_commit(frame_commit),
  .frame_word  (frame_word),
  .dac_a_o     (dac_a_o),
  .dac_b_o     (dac_b_o),
  .buf_o       (buf_o),
  .speed_o     (speed_o),
  .pwrdn_o     (pwrdn_o)
);

// File: tb/test_sdl_word_loader.sv
`timescale 1ns/1ps
module test_sdl_word_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [7:0] dac_a, dac_b, bufv;
  logic speed, pwrdn;

  always #4 clk = ~clk;  // 125 MHz

  sdl_word_loader i_sdl_word_loader (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .dac_a_o(dac_a), .dac_b_o(dac_b), .buf_o(bufv), .speed_o(speed), .pwrdn_o(pwrdn)
  );

  typedef struct {
    int         due;
    string      tag;
    logic [7:0] a, b, bf;
    logic       s, p;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_a = 0, m_b = 0, m_bf = 0;
  logic m_s = 0, m_p = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor / scoreboard
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if ({dac_a, dac_b, bufv, speed, pwrdn} !== {e.a, e.b, e.bf, e.s, e.p}) begin
        n_fail++;
        $display("FAIL %s: got a=%h b=%h buf=%h spd=%b pd=%b exp a=%h b=%h buf=%h spd=%b pd=%b",
                 e.tag, dac_a, dac_b, bufv, speed, pwrdn, e.a, e.b, e.bf, e.s, e.p);
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(string tag, int dly);
    exp_t e;
    e.due = cyc + dly; e.tag = tag;
    e.a = m_a; e.b = m_b; e.bf = m_bf; e.s = m_s; e.p = m_p;
    q.push_back(e);
  endtask

  function automatic void model(logic [15:0] w);
    case (w[15:12])
      4'b0000: begin m_b = m_bf; m_a = w[11:4]; end
      4'b0001: m_bf = w[11:4];
      4'b1000: m_b = w[11:4];
      4'b1001: begin m_s = w[4]; m_p = w[5]; end
      default: ;
    endcase
  endfunction

  task automatic send_bit(logic b);
    sclk = 1'b1; din = b; wait_clk(4);
    sclk = 1'b0; wait_clk(4);
  endtask

  // drive n bits of w (MSB first), optionally extra bits, then close
  task automatic frame(string tag, logic [15:0] w, int n, int extra);
    cs_n = 1'b0; wait_clk(4);
    for (int i = 0; i < n; i++) send_bit(w[15-i]);
    for (int i = 0; i < extra; i++) send_bit(1'b1);
    wait_clk(4); cs_n = 1'b1; wait_clk(4);
    if (n > 0) model((w >> (16 - n)) << (16 - n));
    push(tag, 6);
    wait_clk(10);
  endtask

  initial begin
    wait_clk(3);
    push("R1 reset", 0);
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(4);
    frame("R4 buffer write", 16'h15A0, 16, 0);
    frame("R3 A write + buffer to B", 16'h033F, 16, 0);    // R2 pad bits ignored
    frame("R5 B direct", 16'h8C70, 16, 0);
    frame("R6 ctrl both set", 16'h9030, 16, 0);
    frame("R6 ctrl pd only", 16'h9020, 16, 0);
    frame("R7 unknown select", 16'h5FF0, 16, 0);
    frame("R4 buffer write 2", 16'h1A50, 16, 0);
    frame("R8 extra bits ignored", 16'h8120, 16, 5);
    frame("R9 short 10 bits to B", 16'h8FFF, 10, 0);
    frame("R9 short 3 bits pads to A", 16'h1FFF, 3, 0);
    frame("R9 zero-bit frame", 16'h1770, 0, 0);
    // R10: serial clock toggling with cs high
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    push("R10 sclk while cs high", 6);
    wait_clk(10);
    // R11: two 8-bit bursts with a gap, cs held low
    begin
      logic [15:0] w = 16'h0E70;
      cs_n = 1'b0; wait_clk(4);
      for (int i = 0; i < 8; i++) send_bit(w[15-i]);
      wait_clk(30);
      push("R11 mid-frame hold", 0);
      wait_clk(2);
      for (int i = 8; i < 16; i++) send_bit(w[15-i]);
      wait_clk(4); cs_n = 1'b1; wait_clk(4);
      model(w);
      push("R11 split transfer", 6);
      wait_clk(10);
    end
    // R12: result due 4 edges after the committing serial edge
    cs_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 15; i++) send_bit(i < 4 ? 1'b0 : 1'b1);  // 0000_1111_1111_111
    sclk = 1'b1; din = 1'b1; wait_clk(4);
    sclk = 1'b0;
    model(16'h0FFF);
    wait_clk(4);
    push("R12 latency", 0);
    wait_clk(4); cs_n = 1'b1; wait_clk(20);
    while (q.size() > 0) wait_clk(1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule